// File: doc/BRIEF.md
# Dot-Clock Panel Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable waveforms for a parallel RGB panel driven by a dot clock. It counts dot clocks within a line and lines within a frame. Both periods, the two sync widths, two combined wait counts, the visible pixel count and the visible line count come from configuration inputs. A wait count is a sync width plus the back porch. It tells the block where the active window begins, so no separate porch registers are needed.

The vertical position is kept as a named phase in a state register, with the states `PH_OFF`, `PH_VSYNC`, `PH_VBACK`, `PH_ACTIVE` and `PH_VFRONT`. The phase transitions are:
- `enter`: from `PH_OFF` when sync is switched on.
- `sync_done`: from `PH_VSYNC` to `PH_VBACK`.
- `wait_done`: from `PH_VBACK` to `PH_ACTIVE`.
- `lines_done`: from `PH_ACTIVE` to `PH_VFRONT`.
- `wrap`: from `PH_VFRONT` back to `PH_VSYNC` at the end of the frame.
- `stop`: from any state to `PH_OFF` when sync is switched off.

Every line-end update re-classifies the next line count. A zero-length phase is therefore skipped.

A pixel-request strobe marks each active dot, so an upstream fetch engine can supply pixel data. A one-cycle frame-start pulse marks the first dot of vertical sync and is used to latch the next frame buffer address. Each panel signal has its own polarity select. A falling-edge dot clock select is passed on to the clock output stage.

Top module: `dotclk_sync_gen`

## Requirements
- R1: After reset, and on the clock edge after `sync_on` is sampled low, the block drives every sync output at its inactive level. The inactive levels are: hsync, vsync and data enable at the complement of their polarity selects, and pixel request and frame start at 0. Both counters return to zero.
- R2: Each line lasts `line_period` dot clocks. Hsync is active for the first `hsync_width` clocks of every line.
- R3: Each frame lasts `frame_period` lines. Vsync is active for the first `vsync_width` lines of the frame.
- R4: Data enable is active on dot h of line v when three conditions hold. First, `h_wait <= h < h_wait + h_valid`. Second, `v_wait <= v < v_wait + act_lines`. Third, v is not a vsync line, because the vsync lines take priority.
- R5: `pix_req_o` is high exactly when data enable is active. Both stay inactive while `run` is low.
- R6: Each polarity select works independently. When it is 1, its signal is active high. When it is 0, its signal is active low.
- R7: `frame_start_o` pulses for one clock on dot 0 of line 0 when `vsync_width` is non-zero. It never pulses when `vsync_width` is zero.
- R8: When `sync_on` rises, the first edge only enters the frame. Dot 0 of line 0 is presented after the second edge.
- R9: `dclk_fall_o` follows `dclk_fall_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_on | input | 1 | Enables the counters and sync outputs |
| run | input | 1 | Allows pixel transfer in the active window |
| line_period | input | 18 | Dot clocks per line |
| frame_period | input | 16 | Lines per frame |
| hsync_width | input | 14 (8 in the narrow variant) | Hsync width in dot clocks |
| vsync_width | input | 18 | Vsync width in lines |
| h_wait | input | 12 | Hsync width plus left margin |
| v_wait | input | 16 | Vsync width plus upper margin |
| h_valid | input | 18 | Visible dots per line |
| act_lines | input | 16 | Visible lines per frame |
| pol_hs_high | input | 1 | Hsync active high when 1 |
| pol_vs_high | input | 1 | Vsync active high when 1 |
| pol_de_high | input | 1 | Data enable active high when 1 |
| dclk_fall_sel | input | 1 | Selects falling-edge dot clock |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_req_o | output | 1 | Active-high pixel request strobe |
| frame_start_o | output | 1 | One-cycle frame-start pulse |
| dclk_fall_o | output | 1 | Dot clock edge select to the clock stage |

## Verification
The four timing outputs are registered. Each one reflects the counter position one edge earlier, and dot 0 of a new frame appears on the second edge after `sync_on` rises. A reference model in the bench steps its own dot and line counts on each rising edge and queues the expected active-sense bits. A monitor pops one entry a quarter period after every edge and applies the current polarity selects. The polarity selects and the edge select act within the same cycle, so those outputs are compared at that point against the expected level.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_VSYNC,
        PH_VBACK,
        PH_ACTIVE,
        PH_VFRONT
    } vphase_e;

    // Vertical phase of a line number; sync lines take priority over the window.
    function automatic vphase_e classify_line(
        input logic [19:0] line,
        input logic [19:0] vs_len,
        input logic [19:0] win_start,
        input logic [19:0] win_end
    );
        if (line < vs_len)
            return PH_VSYNC;
        else if (line < win_start)
            return PH_VBACK;
        else if (line < win_end)
            return PH_ACTIVE;
        else
            return PH_VFRONT;
    endfunction

endpackage

// File: rtl/dsg_line_ctr.sv
module dsg_line_ctr #(
    parameter int LP_W = 18,
    parameter int CW   = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic [LP_W-1:0] period,
    output logic [LP_W-1:0] hcnt,
    output logic            line_end
);
    logic [CW-1:0] inc;
    logic          wrap;

    assign inc      = {{(CW-LP_W){1'b0}}, hcnt} + CW'(1);
    assign wrap     = inc >= {{(CW-LP_W){1'b0}}, period};
    assign line_end = adv && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hcnt <= '0;
        else if (!adv || wrap)
            hcnt <= '0;
        else
            hcnt <= inc[LP_W-1:0];
    end
endmodule

// File: rtl/dsg_frame_fsm.sv
module dsg_frame_fsm
    import dsg_pkg::*;
#(
    parameter int FP_W  = 16,
    parameter int VSW_W = 18,
    parameter int CW    = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_on,
    input  logic             line_end,
    input  logic [FP_W-1:0]  frame_period,
    input  logic [VSW_W-1:0] vsync_width,
    input  logic [CW-1:0]    vwin_start,
    input  logic [CW-1:0]    vwin_end,
    output logic [FP_W-1:0]  vcnt,
    output vphase_e          phase
);
    vphase_e         ph_nxt;
    logic [FP_W-1:0] v_nxt;
    logic [CW-1:0]   vinc;
    logic [FP_W-1:0] v_wrapped;
    logic [CW-1:0]   vsw_ext;

    assign vinc      = {{(CW-FP_W){1'b0}}, vcnt} + CW'(1);
    assign v_wrapped = (vinc >= {{(CW-FP_W){1'b0}}, frame_period}) ? '0 : vinc[FP_W-1:0];
    assign vsw_ext   = {{(CW-VSW_W){1'b0}}, vsync_width};

    // Next-state logic: enter, sync_done, wait_done, lines_done, wrap, stop
    always_comb begin
        v_nxt  = vcnt;
        ph_nxt = phase;
        unique case (phase)
            PH_OFF: begin
                v_nxt  = '0;
                ph_nxt = classify_line('0, vsw_ext, vwin_start, vwin_end);
            end
            PH_VSYNC, PH_VBACK, PH_ACTIVE, PH_VFRONT: begin
                v_nxt  = line_end ? v_wrapped : vcnt;
                ph_nxt = classify_line({{(CW-FP_W){1'b0}}, v_nxt},
                                       vsw_ext, vwin_start, vwin_end);
            end
            default: begin
                v_nxt  = '0;
                ph_nxt = PH_OFF;
            end
        endcase
        if (!sync_on) begin
            v_nxt  = '0;
            ph_nxt = PH_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_OFF;
            vcnt  <= '0;
        end else begin
            phase <= ph_nxt;
            vcnt  <= v_nxt;
        end
    end
endmodule

// File: rtl/dsg_out_stage.sv
module dsg_out_stage
    import dsg_pkg::*;
#(
    parameter int LP_W = 18,
    parameter int FP_W = 16,
    parameter int CW   = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_on,
    input  logic            run,
    input  vphase_e         phase,
    input  logic [LP_W-1:0] hcnt,
    input  logic [FP_W-1:0] vcnt,
    input  logic [CW-1:0]   hsw_len,
    input  logic [CW-1:0]   hwin_start,
    input  logic [CW-1:0]   hwin_end,
    output logic            hs_a,
    output logic            vs_a,
    output logic            de_a,
    output logic            fs_a
);
    logic [CW-1:0] hx;
    logic          hs_n, vs_n, de_n, fs_n;
    logic          in_hwin;

    assign hx      = {{(CW-LP_W){1'b0}}, hcnt};
    assign in_hwin = (hx >= hwin_start) && (hx < hwin_end);

    always_comb begin
        hs_n = 1'b0;
        vs_n = 1'b0;
        de_n = 1'b0;
        fs_n = 1'b0;
        unique case (phase)
            PH_OFF: ;
            PH_VSYNC: begin
                hs_n = hx < hsw_len;
                vs_n = 1'b1;
                fs_n = (vcnt == '0) && (hcnt == '0);
            end
            PH_VBACK, PH_VFRONT: begin
                hs_n = hx < hsw_len;
            end
            PH_ACTIVE: begin
                hs_n = hx < hsw_len;
                de_n = run && in_hwin;
            end
            default: ;
        endcase
        if (!sync_on) begin
            hs_n = 1'b0;
            vs_n = 1'b0;
            de_n = 1'b0;
            fs_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_a <= 1'b0;
            vs_a <= 1'b0;
            de_a <= 1'b0;
            fs_a <= 1'b0;
        end else begin
            hs_a <= hs_n;
            vs_a <= vs_n;
            de_a <= de_n;
            fs_a <= fs_n;
        end
    end
endmodule

// File: rtl/dotclk_sync_gen.sv
module dotclk_sync_gen
    import dsg_pkg::*;
#(
    parameter int LP_W     = 18,
    parameter int FP_W     = 16,
    parameter int VSW_W    = 18,
    parameter int HWT_W    = 12,
    parameter int VWT_W    = 16,
    parameter int HV_W     = 18,
    parameter int AL_W     = 16,
    parameter bit WIDE_HSW = 1'b1,
    localparam int HSW_W   = WIDE_HSW ? 14 : 8,
    localparam int CW      = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_on,
    input  logic             run,
    input  logic [LP_W-1:0]  line_period,
    input  logic [FP_W-1:0]  frame_period,
    input  logic [HSW_W-1:0] hsync_width,
    input  logic [VSW_W-1:0] vsync_width,
    input  logic [HWT_W-1:0] h_wait,
    input  logic [VWT_W-1:0] v_wait,
    input  logic [HV_W-1:0]  h_valid,
    input  logic [AL_W-1:0]  act_lines,
    input  logic             pol_hs_high,
    input  logic             pol_vs_high,
    input  logic             pol_de_high,
    input  logic             dclk_fall_sel,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             pix_req_o,
    output logic             frame_start_o,
    output logic             dclk_fall_o
);
    vphase_e         phase;
    logic [LP_W-1:0] hcnt;
    logic [FP_W-1:0] vcnt;
    logic            line_end;
    logic            adv;
    logic            hs_a, vs_a, de_a, fs_a;
    logic [CW-1:0]   hsw_len, hwin_start, hwin_end, vwin_start, vwin_end;

    // Width of the hsync field depends on the variant
    generate
        if (WIDE_HSW) begin : g_hsw_wide
            assign hsw_len = {{(CW-14){1'b0}}, hsync_width[13:0]};
        end else begin : g_hsw_narrow
            assign hsw_len = {{(CW-8){1'b0}}, hsync_width[7:0]};
        end
    endgenerate

    assign hwin_start = {{(CW-HWT_W){1'b0}}, h_wait};
    assign hwin_end   = hwin_start + {{(CW-HV_W){1'b0}}, h_valid};
    assign vwin_start = {{(CW-VWT_W){1'b0}}, v_wait};
    assign vwin_end   = vwin_start + {{(CW-AL_W){1'b0}}, act_lines};

    assign adv = sync_on && (phase != PH_OFF);

    dsg_line_ctr #(.LP_W(LP_W), .CW(CW)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .period   (line_period),
        .hcnt     (hcnt),
        .line_end (line_end)
    );

    dsg_frame_fsm #(.FP_W(FP_W), .VSW_W(VSW_W), .CW(CW)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_on      (sync_on),
        .line_end     (line_end),
        .frame_period (frame_period),
        .vsync_width  (vsync_width),
        .vwin_start   (vwin_start),
        .vwin_end     (vwin_end),
        .vcnt         (vcnt),
        .phase        (phase)
    );

    dsg_out_stage #(.LP_W(LP_W), .FP_W(FP_W), .CW(CW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_on    (sync_on),
        .run        (run),
        .phase      (phase),
        .hcnt       (hcnt),
        .vcnt       (vcnt),
        .hsw_len    (hsw_len),
        .hwin_start (hwin_start),
        .hwin_end   (hwin_end),
        .hs_a       (hs_a),
        .vs_a       (vs_a),
        .de_a       (de_a),
        .fs_a       (fs_a)
    );

    assign hsync_o       = pol_hs_high ? hs_a : ~hs_a;
    assign vsync_o       = pol_vs_high ? vs_a : ~vs_a;
    assign de_o          = pol_de_high ? de_a : ~de_a;
    assign pix_req_o     = de_a;
    assign frame_start_o = fs_a;
    assign dclk_fall_o   = dclk_fall_sel;
endmodule

// File: rtl/dsg_sync_chk.sv
module dsg_sync_chk #(
    parameter int LP_W = 18,
    parameter int FP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sync_on,
    input logic            run,
    input logic            hs_a,
    input logic            vs_a,
    input logic            de_a,
    input logic            fs_a,
    input logic            pix_req_o,
    input logic [LP_W-1:0] hcnt,
    input logic [FP_W-1:0] vcnt
);
    // R1
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_on |=> (!hs_a && !vs_a && !de_a && !fs_a && hcnt == '0 && vcnt == '0));

    // R2
    hcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt != '0) |-> (hcnt == LP_W'($past(hcnt) + LP_W'(1))));

    // R4
    de_not_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de_a |-> !vs_a);

    // R5
    run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pix_req_o);

    // R7
    fs_in_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fs_a |-> vs_a);

    // R8
    startup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_on) |=> (hcnt == '0));
endmodule

bind dotclk_sync_gen dsg_sync_chk #(.LP_W(LP_W), .FP_W(FP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_on   (sync_on),
    .run       (run),
    .hs_a      (hs_a),
    .vs_a      (vs_a),
    .de_a      (de_a),
    .fs_a      (fs_a),
    .pix_req_o (pix_req_o),
    .hcnt      (hcnt),
    .vcnt      (vcnt)
);

// File: tb/dotclk_sync_gen_test.sv
module dotclk_sync_gen_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_on = 1'b0;
    logic        run = 1'b0;
    logic [17:0] line_period = 18'd12;
    logic [15:0] frame_period = 16'd8;
    logic [13:0] hsync_width = 14'd2;
    logic [17:0] vsync_width = 18'd1;
    logic [11:0] h_wait = 12'd4;
    logic [15:0] v_wait = 16'd2;
    logic [17:0] h_valid = 18'd5;
    logic [15:0] act_lines = 16'd3;
    logic        pol_hs_high = 1'b0;
    logic        pol_vs_high = 1'b0;
    logic        pol_de_high = 1'b0;
    logic        dclk_fall_sel = 1'b0;
    logic        hsync_o, vsync_o, de_o, pix_req_o, frame_start_o, dclk_fall_o;

    int    checks = 0;
    int    errors = 0;
    string ctx = "R1";
    logic [4:0] exp_q[$];
    bit    m_on = 1'b0;
    int    mh = 0;
    int    mv = 0;
    bit    done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    dotclk_sync_gen uut (
        .clk(clk), .rst_n(rst_n), .sync_on(sync_on), .run(run),
        .line_period(line_period), .frame_period(frame_period),
        .hsync_width(hsync_width), .vsync_width(vsync_width),
        .h_wait(h_wait), .v_wait(v_wait), .h_valid(h_valid), .act_lines(act_lines),
        .pol_hs_high(pol_hs_high), .pol_vs_high(pol_vs_high), .pol_de_high(pol_de_high),
        .dclk_fall_sel(dclk_fall_sel),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_req_o(pix_req_o),
        .frame_start_o(frame_start_o), .dclk_fall_o(dclk_fall_o)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual=%0b expected=%0b at %0t", tag, ctx, act, exp, $time);
        end
    endtask

    // Reference model: expected active-sense bits {fs, pix, de, vs, hs} after each edge
    always @(posedge clk) begin
        logic [4:0] e;
        e = 5'b0;
        if (!rst_n || !sync_on) begin
            m_on = 1'b0; mh = 0; mv = 0;
        end else if (!m_on) begin
            m_on = 1'b1;
        end else begin
            bit vs, act;
            vs  = mv < int'(vsync_width);
            act = run && !vs && mv >= int'(v_wait) && mv < int'(v_wait) + int'(act_lines)
                  && mh >= int'(h_wait) && mh < int'(h_wait) + int'(h_valid);
            e[0] = mh < int'(hsync_width);
            e[1] = vs;
            e[2] = act;
            e[3] = act;
            e[4] = (mh == 0) && (mv == 0) && (vsync_width != 0);
            if (mh + 1 >= int'(line_period)) begin
                mh = 0;
                mv = (mv + 1 >= int'(frame_period)) ? 0 : mv + 1;
            end else begin
                mh = mh + 1;
            end
        end
        exp_q.push_back(e);
    end

    // Monitor: pops one expected entry per edge, applies present polarity
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (exp_q.size() > 0) begin
                logic [4:0] e;
                e = exp_q.pop_front();
                chk("R2 hsync", hsync_o, pol_hs_high ? e[0] : ~e[0]);
                chk("R3 vsync", vsync_o, pol_vs_high ? e[1] : ~e[1]);
                chk("R4 de", de_o, pol_de_high ? e[2] : ~e[2]);
                chk("R5 pix_req", pix_req_o, e[3]);
                chk("R7 frame_start", frame_start_o, e[4]);
            end
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int fs_seen;
        cycles(3);
        // R1: reset state, all active-low so inactive level is 1
        ctx = "R1";
        chk("R1 reset hsync", hsync_o, 1'b1);
        chk("R1 reset vsync", vsync_o, 1'b1);
        chk("R1 reset de", de_o, 1'b1);
        chk("R1 reset frame_start", frame_start_o, 1'b0);
        rst_n = 1'b1;
        cycles(3);

        // R8: frame entry takes one edge, dot 0 appears after the second
        ctx = "R8";
        sync_on = 1'b1;
        run = 1'b1;
        @(posedge clk); #(PERIOD/4);
        chk("R8 first edge no frame_start", frame_start_o, 1'b0);
        @(posedge clk); #(PERIOD/4);
        chk("R8 second edge frame_start", frame_start_o, 1'b1);
        ctx = "R2/R3/R4";
        cycles(200);

        // R5: run low keeps pixel requests off
        ctx = "R5";
        run = 1'b0;
        cycles(100);
        run = 1'b1;
        cycles(30);

        // R1: sync off mid-frame
        ctx = "R1";
        sync_on = 1'b0;
        cycles(15);

        // R6: per-signal polarity, mixed settings, while off
        ctx = "R6";
        pol_hs_high = 1'b1; pol_vs_high = 1'b0; pol_de_high = 1'b1;
        #1;
        chk("R6 hsync inactive high-pol", hsync_o, 1'b0);
        chk("R6 vsync inactive low-pol", vsync_o, 1'b1);
        chk("R6 de inactive high-pol", de_o, 1'b0);
        // R9
        dclk_fall_sel = 1'b1;
        #1;
        chk("R9 dclk_fall set", dclk_fall_o, 1'b1);
        dclk_fall_sel = 1'b0;
        #1;
        chk("R9 dclk_fall clear", dclk_fall_o, 1'b0);
        pol_vs_high = 1'b1;

        // Second timing with window reaching line and frame ends
        cycles(2);
        line_period = 18'd9; hsync_width = 14'd3; h_wait = 12'd3; h_valid = 18'd6;
        frame_period = 16'd10; vsync_width = 18'd3; v_wait = 16'd4; act_lines = 16'd6;
        ctx = "R2/R3/R4 timing B";
        sync_on = 1'b1;
        cycles(250);

        // R7: zero-width vsync gives no frame-start pulse
        sync_on = 1'b0;
        cycles(3);
        vsync_width = 18'd0; v_wait = 16'd1; act_lines = 16'd2;
        ctx = "R7";
        sync_on = 1'b1;
        fs_seen = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #(PERIOD/4);
            if (frame_start_o) fs_seen++;
        end
        chk("R7 no pulse with zero vsync", fs_seen != 0, 1'b0);
        @(negedge clk);
        sync_on = 1'b0;
        cycles(5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule